// File: doc/BRIEF.md
# Deferred Invalidation Load Window

This block is a per-line coherence controller for a private cache. It keeps a read-only line usable by the core for a limited time after the core has acknowledged an invalidation for that line. The acknowledgement leaves at once, so the requester is never held up. The acknowledged line moves to a deferred-stale condition and keeps answering loads with its old contents until a closing event occurs. At that point the line is finally invalidated and the kill is reported on a per-line mask.

The closing event depends on a mode input. In basic mode the window closes when the core issues its next miss request. In extended mode it closes only when the bus snoop reports that the core's own request has been serialized, so a request that has been issued but not yet ordered does not shorten the window. A second input selects a sequentially consistent configuration, in which only one deferred line may exist at a time. A line fill for any index installs fresh data, and a fill for a deferred line ends its stale condition. The data array is outside the block; only hit and miss decisions are produced here.

Top module: `dil_window_ctrl`

## Requirements
- R1: After reset every line is invalid: loads and stores miss, and inv_ack, ld_hit, ld_miss, st_hit, st_miss and kill_mask are all zero.
- R2: Each cycle with inv_valid high gives exactly one inv_ack pulse, in the following cycle, whatever the state of the target line.
- R3: An invalidation of a read-only line makes it deferred-stale, and loads to that line keep reporting ld_hit until the window closes.
- R4: An invalidation of a writable or invalid line leaves it invalid at once, without deferral and without a kill_mask bit.
- R5: With mode_ext low, miss_issue closes the window. Every stale line's kill_mask bit is high in the next cycle, and later loads to that line miss. A load given in the same cycle as the closing event still hits.
- R6: With mode_ext high, miss_issue has no effect on stale lines. own_serialized closes the window in the way R5 describes.
- R7: st_hit is reported only for a writable line. A store to a read-only or deferred-stale line reports st_miss.
- R8: With sc_mode high, at most one line is stale. An invalidation that defers a new line kills the older stale line, and that kill_mask bit is raised in the same cycle as the new inv_ack.
- R9: With sc_mode low, several lines can be stale at once. One closing event kills all of them together in a single kill_mask value.
- R10: A fill (fill_excl=1 writable, 0 read-only) on a stale line clears its stale condition. A closing event in the same cycle then raises no kill for that line, and the line hits afterwards.
- R11: Each load or store gives exactly one of hit or miss, registered, in the cycle after the request; with no request both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ext | input | 1 | 0: close window on miss issue, 1: close on own-request serialization |
| sc_mode | input | 1 | 1: at most one deferred-stale line |
| inv_valid | input | 1 | Incoming invalidation |
| inv_idx | input | IDX_W | Line targeted by the invalidation |
| ld_valid | input | 1 | Core load request |
| ld_idx | input | IDX_W | Line for the load |
| st_valid | input | 1 | Core store request |
| st_idx | input | IDX_W | Line for the store |
| miss_issue | input | 1 | Core issued a miss request |
| own_serialized | input | 1 | Bus snoop saw the core's own request ordered |
| fill_valid | input | 1 | Line fill |
| fill_idx | input | IDX_W | Line being filled |
| fill_excl | input | 1 | Fill grants write permission |
| inv_ack | output | 1 | Invalidation acknowledgement |
| ld_hit | output | 1 | Load hit |
| ld_miss | output | 1 | Load miss |
| st_hit | output | 1 | Store hit |
| st_miss | output | 1 | Store miss |
| kill_mask | output | NUM_LINES | Final invalidation of deferred lines, one bit per line |

## Verification
The bench builds the block with NUM_LINES set to 4. With so few lines, every slot can be made stale and collisions between an invalidation, a fill and a closing event can be set up on purpose. Both mode inputs are inputs rather than parameters, so one build covers basic and extended closing and both the single-stale and multi-stale configurations. A pseudo-random phase then mixes all events with the modes changing on the fly. A behavioural line-state model checks every cycle of that phase.

// File: rtl/dil_pkg.sv
package dil_pkg;
  typedef enum logic [1:0] {
    LN_INV   = 2'd0,
    LN_RO    = 2'd1,
    LN_RW    = 2'd2,
    LN_STALE = 2'd3
  } line_st_e;
endpackage

// File: rtl/dil_line_slot.sv
module dil_line_slot
  import dil_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inv_hit,
  input  logic fill_hit,
  input  logic fill_excl,
  input  logic close_req,
  input  logic evict_req,
  output logic is_ro,
  output logic is_rw,
  output logic is_stale,
  output logic kill
);
  line_st_e st_q, st_d;

  always_comb begin
    kill = (st_q == LN_STALE) && (close_req || evict_req) && !fill_hit;
    st_d = st_q;
    if (kill) begin
      st_d = LN_INV;
    end else if (inv_hit) begin
      st_d = (st_q == LN_RO || st_q == LN_STALE) ? LN_STALE : LN_INV;
    end else if (fill_hit) begin
      st_d = fill_excl ? LN_RW : LN_RO;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LN_INV;
    else     st_q <= st_d;
  end

  assign is_ro    = (st_q == LN_RO);
  assign is_rw    = (st_q == LN_RW);
  assign is_stale = (st_q == LN_STALE);
endmodule

// File: rtl/dil_event_gen.sv
module dil_event_gen #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 mode_ext,
  input  logic                 sc_mode,
  input  logic                 miss_issue,
  input  logic                 own_serialized,
  input  logic                 inv_valid,
  input  logic [IDX_W-1:0]     inv_idx,
  input  logic [NUM_LINES-1:0] ro_vec,
  output logic                 close_req,
  output logic [NUM_LINES-1:0] evict_vec
);
  logic new_defer;

  always_comb begin
    close_req = mode_ext ? own_serialized : miss_issue;
    new_defer = inv_valid && ro_vec[inv_idx];
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_evict
    assign evict_vec[g] = sc_mode && new_defer && (inv_idx != IDX_W'(g));
  end
endmodule

// File: rtl/dil_resp_stage.sv
module dil_resp_stage #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inv_valid,
  input  logic                 ld_valid,
  input  logic [IDX_W-1:0]     ld_idx,
  input  logic                 st_valid,
  input  logic [IDX_W-1:0]     st_idx,
  input  logic [NUM_LINES-1:0] ro_vec,
  input  logic [NUM_LINES-1:0] rw_vec,
  input  logic [NUM_LINES-1:0] stale_vec,
  input  logic [NUM_LINES-1:0] kill_vec,
  output logic                 inv_ack,
  output logic                 ld_hit,
  output logic                 ld_miss,
  output logic                 st_hit,
  output logic                 st_miss,
  output logic [NUM_LINES-1:0] kill_mask
);
  logic ld_ok, st_ok;

  always_comb begin
    ld_ok = ro_vec[ld_idx] || rw_vec[ld_idx] || stale_vec[ld_idx];
    st_ok = rw_vec[st_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_ack   <= 1'b0;
      ld_hit    <= 1'b0;
      ld_miss   <= 1'b0;
      st_hit    <= 1'b0;
      st_miss   <= 1'b0;
      kill_mask <= '0;
    end else begin
      inv_ack   <= inv_valid;
      ld_hit    <= ld_valid && ld_ok;
      ld_miss   <= ld_valid && !ld_ok;
      st_hit    <= st_valid && st_ok;
      st_miss   <= st_valid && !st_ok;
      kill_mask <= kill_vec;
    end
  end
endmodule

// File: rtl/dil_window_ctrl.sv
module dil_window_ctrl #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_ext,
  input  logic                 sc_mode,
  input  logic                 inv_valid,
  input  logic [IDX_W-1:0]     inv_idx,
  input  logic                 ld_valid,
  input  logic [IDX_W-1:0]     ld_idx,
  input  logic                 st_valid,
  input  logic [IDX_W-1:0]     st_idx,
  input  logic                 miss_issue,
  input  logic                 own_serialized,
  input  logic                 fill_valid,
  input  logic [IDX_W-1:0]     fill_idx,
  input  logic                 fill_excl,
  output logic                 inv_ack,
  output logic                 ld_hit,
  output logic                 ld_miss,
  output logic                 st_hit,
  output logic                 st_miss,
  output logic [NUM_LINES-1:0] kill_mask
);
  logic [NUM_LINES-1:0] ro_vec, rw_vec, stale_vec, kill_vec, evict_vec;
  logic                 close_req;

  dil_event_gen #(.NUM_LINES(NUM_LINES)) evt_i (
    .mode_ext(mode_ext), .sc_mode(sc_mode), .miss_issue(miss_issue),
    .own_serialized(own_serialized), .inv_valid(inv_valid), .inv_idx(inv_idx),
    .ro_vec(ro_vec), .close_req(close_req), .evict_vec(evict_vec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    dil_line_slot slot_i (
      .clk(clk), .rst(rst),
      .inv_hit(inv_valid && inv_idx == IDX_W'(g)),
      .fill_hit(fill_valid && fill_idx == IDX_W'(g)),
      .fill_excl(fill_excl),
      .close_req(close_req),
      .evict_req(evict_vec[g]),
      .is_ro(ro_vec[g]), .is_rw(rw_vec[g]), .is_stale(stale_vec[g]),
      .kill(kill_vec[g])
    );
  end

  dil_resp_stage #(.NUM_LINES(NUM_LINES)) resp_i (
    .clk(clk), .rst(rst), .inv_valid(inv_valid),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .st_valid(st_valid), .st_idx(st_idx),
    .ro_vec(ro_vec), .rw_vec(rw_vec), .stale_vec(stale_vec), .kill_vec(kill_vec),
    .inv_ack(inv_ack), .ld_hit(ld_hit), .ld_miss(ld_miss),
    .st_hit(st_hit), .st_miss(st_miss), .kill_mask(kill_mask)
  );
endmodule

// File: rtl/dil_window_chk.sv
module dil_window_chk #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 mode_ext,
  input logic                 sc_mode,
  input logic                 inv_valid,
  input logic                 ld_valid,
  input logic                 st_valid,
  input logic [IDX_W-1:0]     st_idx,
  input logic                 miss_issue,
  input logic                 own_serialized,
  input logic                 fill_valid,
  input logic                 inv_ack,
  input logic                 ld_hit,
  input logic                 ld_miss,
  input logic                 st_hit,
  input logic [NUM_LINES-1:0] kill_mask,
  input logic [NUM_LINES-1:0] stale_vec
);
  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (rst)
    inv_valid |=> inv_ack);
  assert_ack_has_cause_R2: assert property (@(posedge clk) disable iff (rst)
    !inv_valid |=> !inv_ack);
  assert_basic_close_R5: assert property (@(posedge clk) disable iff (rst)
    (!mode_ext && miss_issue && !inv_valid) |=> (stale_vec == '0));
  assert_ext_ignores_miss_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_ext && !own_serialized && !inv_valid && !fill_valid)
      |=> (stale_vec == $past(stale_vec)));
  assert_no_stale_store_R7: assert property (@(posedge clk) disable iff (rst)
    (st_valid && stale_vec[st_idx]) |=> !st_hit);
  assert_single_stale_R8: assert property (@(posedge clk) disable iff (rst)
    (sc_mode && $countones(stale_vec) <= 1) |=> ($countones(stale_vec) <= 1));
  assert_single_kill_R8: assert property (@(posedge clk) disable iff (rst)
    (sc_mode && $countones(stale_vec) <= 1) |=> $onehot0(kill_mask));
  assert_one_result_R11: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> (ld_hit != ld_miss));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> (!ld_hit && !ld_miss));
endmodule

bind dil_window_ctrl dil_window_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rst(rst), .mode_ext(mode_ext), .sc_mode(sc_mode),
  .inv_valid(inv_valid), .ld_valid(ld_valid), .st_valid(st_valid), .st_idx(st_idx),
  .miss_issue(miss_issue), .own_serialized(own_serialized), .fill_valid(fill_valid),
  .inv_ack(inv_ack), .ld_hit(ld_hit), .ld_miss(ld_miss), .st_hit(st_hit),
  .kill_mask(kill_mask), .stale_vec(stale_vec)
);

// File: tb/dil_window_ctrl_tb_top.sv
module dil_window_ctrl_tb_top;
  localparam int NL = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_ext = 0, sc_mode = 1;
  logic inv_valid = 0, ld_valid = 0, st_valid = 0;
  logic [IW-1:0] inv_idx = 0, ld_idx = 0, st_idx = 0, fill_idx = 0;
  logic miss_issue = 0, own_serialized = 0, fill_valid = 0, fill_excl = 0;
  logic inv_ack, ld_hit, ld_miss, st_hit, st_miss;
  logic [NL-1:0] kill_mask;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  // model line codes: 0 invalid, 1 read-only, 2 writable, 3 deferred-stale
  int m_line [NL];
  logic e_ack, e_lh, e_lm, e_sh, e_sm;
  logic [NL-1:0] e_kill;

  always #4 clk = ~clk;

  dil_window_ctrl #(.NUM_LINES(NL)) dut_i (
    .clk(clk), .rst(rst), .mode_ext(mode_ext), .sc_mode(sc_mode),
    .inv_valid(inv_valid), .inv_idx(inv_idx), .ld_valid(ld_valid), .ld_idx(ld_idx),
    .st_valid(st_valid), .st_idx(st_idx), .miss_issue(miss_issue),
    .own_serialized(own_serialized), .fill_valid(fill_valid), .fill_idx(fill_idx),
    .fill_excl(fill_excl), .inv_ack(inv_ack), .ld_hit(ld_hit), .ld_miss(ld_miss),
    .st_hit(st_hit), .st_miss(st_miss), .kill_mask(kill_mask)
  );

  task automatic model_eval();
    bit cls, defer;
    int nxt [NL];
    cls   = mode_ext ? own_serialized : miss_issue;
    defer = inv_valid && m_line[inv_idx] == 1;
    e_ack = inv_valid;
    e_lh  = ld_valid && m_line[ld_idx] != 0;
    e_lm  = ld_valid && m_line[ld_idx] == 0;
    e_sh  = st_valid && m_line[st_idx] == 2;
    e_sm  = st_valid && m_line[st_idx] != 2;
    for (int i = 0; i < NL; i++) begin
      bit ev, kl;
      ev = sc_mode && defer && inv_idx != i;
      kl = m_line[i] == 3 && (cls || ev) && !(fill_valid && fill_idx == i);
      e_kill[i] = kl;
      nxt[i] = m_line[i];
      if (kl) nxt[i] = 0;
      else if (inv_valid && inv_idx == i) nxt[i] = (m_line[i] == 1 || m_line[i] == 3) ? 3 : 0;
      else if (fill_valid && fill_idx == i) nxt[i] = fill_excl ? 2 : 1;
    end
    for (int i = 0; i < NL; i++) m_line[i] = nxt[i];
  endtask

  task automatic compare(input string req);
    n_checks++;
    if ({inv_ack, ld_hit, ld_miss, st_hit, st_miss, kill_mask} !==
        {e_ack, e_lh, e_lm, e_sh, e_sm, e_kill}) begin
      n_fail++;
      $display("FAIL %s: ack/lh/lm/sh/sm/kill actual %b%b%b%b%b %b expected %b%b%b%b%b %b",
        req, inv_ack, ld_hit, ld_miss, st_hit, st_miss, kill_mask,
        e_ack, e_lh, e_lm, e_sh, e_sm, e_kill);
    end
  endtask

  // inputs are set before this task, which runs from a falling edge
  task automatic step(input string req);
    model_eval();
    @(posedge clk);
    @(negedge clk);
    compare(req);
    inv_valid = 0; ld_valid = 0; st_valid = 0; miss_issue = 0;
    own_serialized = 0; fill_valid = 0; fill_excl = 0;
  endtask

  task automatic do_fill(input int i, input bit ex);
    fill_valid = 1; fill_idx = IW'(i); fill_excl = ex; step("R10");
  endtask
  task automatic do_inv(input int i, input string req);
    inv_valid = 1; inv_idx = IW'(i); step(req);
  endtask
  task automatic do_ld(input int i, input string req);
    ld_valid = 1; ld_idx = IW'(i); step(req);
  endtask
  task automatic do_st(input int i, input string req);
    st_valid = 1; st_idx = IW'(i); step(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NL; i++) m_line[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, every line misses
    e_ack = 0; e_lh = 0; e_lm = 0; e_sh = 0; e_sm = 0; e_kill = '0;
    compare("R1");
    do_ld(2, "R1");
    do_st(1, "R1");

    // install lines 0..2 read-only, 3 writable
    sc_mode = 1; mode_ext = 0;
    do_fill(0, 0); do_fill(1, 0); do_fill(2, 0); do_fill(3, 1);
    do_ld(0, "R11"); do_st(3, "R7");
    // R3: invalidate read-only line, keep loading
    do_inv(0, "R2");
    do_ld(0, "R3"); do_ld(0, "R3");
    do_st(0, "R7");
    do_st(1, "R7");
    // R5: miss_issue closes, load in same cycle still hits
    miss_issue = 1; ld_valid = 1; ld_idx = 0; step("R5");
    do_ld(0, "R5");
    // R8: second deferral evicts older one
    do_fill(0, 0);
    do_inv(0, "R8");
    do_inv(1, "R8");
    do_ld(0, "R8"); do_ld(1, "R8");
    // R6: extended mode ignores miss issue
    mode_ext = 1;
    miss_issue = 1; step("R6");
    do_ld(1, "R6");
    own_serialized = 1; step("R6");
    do_ld(1, "R6");
    // R4: writable and invalid lines die at once
    do_inv(3, "R4"); do_ld(3, "R4");
    do_inv(1, "R4"); do_ld(1, "R4");
    // R9: several stale lines in non-SC mode, killed together
    sc_mode = 0; mode_ext = 0;
    do_fill(0, 0); do_fill(1, 0); do_fill(2, 0);
    do_inv(0, "R9"); do_inv(1, "R9"); do_inv(2, "R9");
    do_ld(1, "R9");
    miss_issue = 1; step("R9");
    do_ld(2, "R9");
    // R10: fill on a stale line with a close in the same cycle
    do_fill(0, 0); do_fill(1, 0);
    do_inv(0, "R10"); do_inv(1, "R10");
    fill_valid = 1; fill_idx = 0; fill_excl = 1; miss_issue = 1; step("R10");
    do_ld(0, "R10"); do_st(0, "R10"); do_ld(1, "R10");
    // R2: back-to-back invalidations, one ack each
    for (int k = 0; k < 6; k++) do_inv(k % NL, "R2");

    // mixed traffic, modes switching
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      inv_valid = lfsr[0] & lfsr[5]; inv_idx = lfsr[2:1];
      ld_valid = lfsr[3]; ld_idx = lfsr[7:6];
      st_valid = lfsr[4] & lfsr[9]; st_idx = lfsr[11:10];
      miss_issue = lfsr[8] & lfsr[12] & lfsr[1];
      own_serialized = lfsr[13] & lfsr[14] & lfsr[2];
      fill_valid = lfsr[15] & lfsr[11]; fill_idx = lfsr[14:13]; fill_excl = lfsr[6];
      if (k % 500 == 0) begin mode_ext = lfsr[9]; sc_mode = lfsr[10]; end
      if (k % 1000 == 0) sc_mode = 1;
      step("R11");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule